// File: doc/BRIEF.md
# SPI Serial EEPROM Command Controller

This block is the slave side of a four-wire serial link in front of a small byte-wide nonvolatile store. Over a chip select, a serial clock and a data-in line it takes an 8-bit opcode, then any address and data bytes, all MSB first. It answers on a single serial output. The commands cover six operations: set and clear the write-enable latch, read and write the status byte, a streaming array read that advances the address by itself, and a page write.

The page write gathers up to 16 bytes in a page buffer. The byte offset wraps inside the page. The buffer is committed to the array only when chip select rises on a byte boundary and three conditions hold: the write-enable latch is set, the write-protect pin is high, and the target page is not locked by the lock field in the status byte. A commit starts a busy interval of `WRITE_CYCLES` system clocks. While it runs, the status byte can still be polled and every other command is discarded.

The serial pins are sampled with the system clock `clk`. The serial clock must therefore stay in each level for at least four `clk` cycles. The state machine has eight states:
- IDLE: chip select is high.
- OPCODE: chip select has fallen.
- ADDR: entered after a read or write opcode.
- RD_DATA: entered after the last address byte of a read.
- WR_DATA: entered after the last address byte of a write.
- SR_OUT: entered after the status-read opcode.
- SR_IN: entered after the status-write opcode.
- DISCARD: entered after latch commands, unknown opcodes, or any non-status command while busy.

Any state returns to IDLE when chip select rises. That transition is also the commit point for WR_DATA and SR_IN.

Top module: `spi_ee_ctrl`

## Requirements
- R1: After reset `so` is 0, and the status byte reads 0x00: not busy, latch clear, lock field 000.
- R2: `si` is sampled on rising `sck` edges and `so` changes after falling edges. Both idle levels of `sck` work (modes 0 and 3), and every byte moves MSB first.
- R3: The status-read opcode 0x05 returns the status byte: bit 0 is busy, bit 1 is the write-enable latch, bits 4:2 are the lock field, and the other bits are 0. The byte repeats for as long as chip select stays low.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R5: Read opcode 0x03 takes two address bytes, of which the low 10 bits are used. It then streams bytes from consecutive addresses, wrapping from 0x3FF to 0x000.
- R6: Without the write-enable latch, a page write (opcode 0x02, two address bytes, data) and a status write (opcode 0x01, one data byte) change nothing.
- R7: An accepted write commits when chip select rises after at least one whole data byte. Busy then reads 1 for `WRITE_CYCLES` clocks, and the write-enable latch is cleared.
- R8: While busy, only the status read acts. Other opcodes change no state, and a read drives `so` low.
- R9: Data bytes of a page write go to consecutive offsets within the 16-byte page of the start address, and wrap to offset 0 after offset 15.
- R10: A write with no data byte, or one ended mid-byte, does not commit and leaves the latch set.
- R11: Lock field encoding: 000 locks nothing, 001 locks page 0, 010 locks the last page, 011 locks the lower half, and 1qq locks quarter qq. A page write into a locked page is discarded and the latch stays set.
- R12: With `wp_n` low, page writes and status writes are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out, 0 when not driving data |

## Verification
Each input pin passes a two-flop synchronizer before the edge detector, so `so` moves about three clocks after the falling `sck` edge. The bench holds every `sck` level for eight clocks and samples `so` just before the next rising edge. A commit starts within a few clocks of chip select rising. The bench therefore polls the status byte straight after a write to see busy set, which is far inside the 2000-clock busy window. It then idles `WRITE_CYCLES` plus 100 clocks before expecting busy clear. Every byte read back goes through a queue of expected values that a monitor process compares in order.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_SR_OUT,
        ST_SR_IN,
        ST_DISCARD
    } ctrl_state_t;

    // Lock field decode: 000 none, 001 first page, 010 last page,
    // 011 lower half, 1qq quarter qq.
    function automatic logic region_locked(input logic [2:0] field,
                                           input int unsigned page,
                                           input int unsigned npages,
                                           input int unsigned pw);
        logic hit;
        case (field)
            3'b000:  hit = 1'b0;
            3'b001:  hit = (page == 0);
            3'b010:  hit = (page == npages - 1);
            3'b011:  hit = (page < (npages >> 1));
            default: hit = ((page >> (pw - 2)) == {30'd0, field[1:0]});
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/spi_ee_link.sv
module spi_ee_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       cs_active,
    output logic       cs_rise,
    output logic [2:0] bit_idx,
    output logic       so
);
    logic [2:0] sck_s;
    logic [1:0] cs_s;
    logic [1:0] si_s;
    logic       cs_prev;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       load_pend;
    logic       so_q;
    logic       rise, fall;

    assign cs_active = !cs_s[1];
    assign cs_rise   = cs_s[1] && !cs_prev;
    assign rise      = cs_active && sck_s[1] && !sck_s[2];
    assign fall      = cs_active && !sck_s[1] && sck_s[2];
    assign byte_done = rise && (bit_idx == 3'd7);
    assign rx_byte   = {rx_sh, si_s[1]};
    assign so        = so_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s   <= '0;
            cs_s    <= '1;
            si_s    <= '0;
            cs_prev <= 1'b1;
        end else begin
            sck_s   <= {sck_s[1:0], sck};
            cs_s    <= {cs_s[0], cs_n};
            si_s    <= {si_s[0], si};
            cs_prev <= cs_s[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            load_pend <= 1'b0;
            so_q      <= 1'b0;
        end else if (!cs_active) begin
            bit_idx   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            load_pend <= 1'b0;
            so_q      <= 1'b0;
        end else if (rise) begin
            rx_sh   <= rx_byte[6:0];
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
                load_pend <= 1'b1;
            end
        end else if (fall) begin
            if (load_pend) begin
                so_q      <= tx_byte[7];
                tx_sh     <= {tx_byte[6:0], 1'b0};
                load_pend <= 1'b0;
            end else begin
                so_q  <= tx_sh[7];
                tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
    parameter int DEPTH        = 1024,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 2000
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   buf_clear,
    input  logic                                   buf_we,
    input  logic [$clog2(PAGE_BYTES)-1:0]          buf_idx,
    input  logic [7:0]                             buf_din,
    input  logic                                   commit_array,
    input  logic                                   commit_status,
    input  logic [$clog2(DEPTH/PAGE_BYTES)-1:0]    commit_page,
    input  logic [$clog2(DEPTH)-1:0]               rd_addr,
    output logic [7:0]                             rd_data,
    output logic                                   busy
);
    localparam int AW = $clog2(DEPTH);
    localparam int OW = $clog2(PAGE_BYTES);
    localparam int PW = AW - OW;
    localparam int TW = $clog2(WRITE_CYCLES + 1);

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic                  committing;
    logic [OW-1:0]         cidx;
    logic [PW-1:0]         cpage;
    logic [TW-1:0]         timer;

    assign busy = committing || (timer != '0);

    always_ff @(posedge clk) begin
        if (buf_we) begin
            pbuf[buf_idx] <= buf_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmask <= '0;
        end else if (buf_clear) begin
            pmask <= '0;
        end else if (buf_we) begin
            pmask[buf_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            committing <= 1'b0;
            cidx       <= '0;
            cpage      <= '0;
            timer      <= '0;
        end else begin
            if (commit_array) begin
                committing <= 1'b1;
                cidx       <= '0;
                cpage      <= commit_page;
            end else if (committing) begin
                cidx <= cidx + 1'b1;
                if (cidx == OW'(PAGE_BYTES - 1)) begin
                    committing <= 1'b0;
                end
            end
            if (commit_array || commit_status) begin
                timer <= TW'(WRITE_CYCLES);
            end else if (timer != '0) begin
                timer <= timer - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (committing && pmask[cidx]) begin
            mem[{cpage, cidx}] <= pbuf[cidx];
        end
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl #(
    parameter int DEPTH        = 1024,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic wp_n,
    output logic so
);
    import spi_ee_pkg::*;

    localparam int          AW         = $clog2(DEPTH);
    localparam int          OW         = $clog2(PAGE_BYTES);
    localparam int          PW         = AW - OW;
    localparam int unsigned PAGES      = DEPTH / PAGE_BYTES;
    localparam int          ADDR_BYTES = (AW + 7) / 8;
    localparam int          CW         = $clog2(ADDR_BYTES) + 1;

    ctrl_state_t   state, state_n;
    logic [7:0]    rx_byte, tx_byte, rd_data, status;
    logic          byte_done, cs_active, cs_rise, busy;
    logic [2:0]    bit_idx;
    logic [AW-1:0] addr_acc, addr_next, ptr;
    logic [CW-1:0] abyte_cnt;
    logic [OW-1:0] wr_off;
    logic          is_read, wr_any, sr_got, wel_q;
    logic [2:0]    sr_new, lock_q;
    logic          page_lock, commit_go, commit_array, commit_status;
    logic          buf_clear, buf_we;

    spi_ee_link link_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .byte_done(byte_done),
        .cs_active(cs_active), .cs_rise(cs_rise), .bit_idx(bit_idx), .so(so)
    );

    spi_ee_store #(
        .DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .buf_clear(buf_clear), .buf_we(buf_we),
        .buf_idx(wr_off), .buf_din(rx_byte), .commit_array(commit_array),
        .commit_status(commit_status), .commit_page(ptr[AW-1:OW]),
        .rd_addr(ptr), .rd_data(rd_data), .busy(busy)
    );

    assign status    = {3'b000, lock_q, wel_q, busy};
    assign addr_next = AW'({addr_acc, rx_byte});
    assign page_lock = region_locked(lock_q, 32'(ptr[AW-1:OW]), PAGES, PW);

    // Commit point: chip select rises on a byte boundary.
    assign commit_go = cs_rise && (bit_idx == 3'd0) && !busy && wel_q && wp_n &&
                       (((state == ST_WR_DATA) && wr_any && !page_lock) ||
                        ((state == ST_SR_IN) && sr_got));
    assign commit_array  = commit_go && (state == ST_WR_DATA);
    assign commit_status = commit_go && (state == ST_SR_IN);
    assign buf_clear     = byte_done && (state == ST_OPCODE) && !busy &&
                           (rx_byte == OP_WRITE);
    assign buf_we        = byte_done && (state == ST_WR_DATA);

    always_comb begin
        unique case (state)
            ST_SR_OUT:  tx_byte = status;
            ST_RD_DATA: tx_byte = rd_data;
            default:    tx_byte = 8'h00;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        if (!cs_active) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_n = ST_OPCODE;
                ST_OPCODE: begin
                    if (byte_done) begin
                        if (rx_byte == OP_RDSR) begin
                            state_n = ST_SR_OUT;
                        end else if (busy) begin
                            state_n = ST_DISCARD;
                        end else begin
                            case (rx_byte)
                                OP_READ, OP_WRITE: state_n = ST_ADDR;
                                OP_WRSR:           state_n = ST_SR_IN;
                                default:           state_n = ST_DISCARD;
                            endcase
                        end
                    end
                end
                ST_ADDR: begin
                    if (byte_done && (abyte_cnt == CW'(ADDR_BYTES - 1))) begin
                        state_n = is_read ? ST_RD_DATA : ST_WR_DATA;
                    end
                end
                ST_RD_DATA, ST_WR_DATA, ST_SR_OUT, ST_SR_IN, ST_DISCARD: state_n = state;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // Datapath and latch outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q     <= 1'b0;
            lock_q    <= '0;
            sr_new    <= '0;
            sr_got    <= 1'b0;
            is_read   <= 1'b0;
            wr_any    <= 1'b0;
            wr_off    <= '0;
            ptr       <= '0;
            addr_acc  <= '0;
            abyte_cnt <= '0;
        end else if (commit_go) begin
            wel_q <= 1'b0;
            if (state == ST_SR_IN) begin
                lock_q <= sr_new;
            end
        end else if (byte_done) begin
            unique case (state)
                ST_OPCODE: begin
                    abyte_cnt <= '0;
                    sr_got    <= 1'b0;
                    if (!busy) begin
                        if (rx_byte == OP_WREN) wel_q <= 1'b1;
                        if (rx_byte == OP_WRDI) wel_q <= 1'b0;
                        is_read <= (rx_byte == OP_READ);
                    end
                end
                ST_ADDR: begin
                    addr_acc  <= addr_next;
                    abyte_cnt <= abyte_cnt + 1'b1;
                    if (abyte_cnt == CW'(ADDR_BYTES - 1)) begin
                        ptr    <= addr_next;
                        wr_off <= addr_next[OW-1:0];
                        wr_any <= 1'b0;
                    end
                end
                ST_RD_DATA: ptr <= ptr + 1'b1;
                ST_WR_DATA: begin
                    wr_off <= wr_off + 1'b1;
                    wr_any <= 1'b1;
                end
                ST_SR_IN: begin
                    sr_new <= rx_byte[4:2];
                    sr_got <= 1'b1;
                end
                ST_IDLE, ST_SR_OUT, ST_DISCARD: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wel,
    input logic [2:0] lock,
    input logic       commit_go,
    input logic       wp_n
);
    // R7: a commit starts the busy interval and clears the latch
    assert_commit_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> (busy && !wel));

    // R6: busy only begins when the latch was set
    assert_busy_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    // R12: busy only begins when write protect was inactive
    assert_busy_needs_wp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wp_n));

    // R8: latch and lock field frozen during busy
    assert_frozen_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(wel) && $stable(lock)));

    // R4: the latch can only be set while not busy
    assert_wel_set_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(busy));
endmodule

bind spi_ee_ctrl spi_ee_checker chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel_q),
    .lock(lock_q), .commit_go(commit_go), .wp_n(wp_n)
);

// File: tb/spi_ee_ctrl_tb_top.sv
module spi_ee_ctrl_tb_top;
    localparam int HALF = 8;
    localparam int WC   = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    logic so;
    logic mode3 = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] act_q[$];
    logic [7:0] dbuf[16];

    always #2 clk = ~clk;

    spi_ee_ctrl #(.WRITE_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .si(si), .wp_n(wp_n), .so(so)
    );

    // Monitor: compare captured bytes against the expected queue in order
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                logic [7:0] a;
                a = act_q.pop_front();
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected byte: actual %02h expected none", a);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (a !== e) begin
                        errors++;
                        $display("FAIL %s: actual %02h expected %02h", t, a, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, input bit capture);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (mode3) sck = 1'b0;
            si = tx[i];
            idle(HALF);
            r[i] = so;
            sck = 1'b1;
            idle(HALF);
            if (!mode3) sck = 1'b0;
        end
        if (capture) act_q.push_back(r);
    endtask

    task automatic cs_begin();
        sck = mode3;
        idle(4);
        cs_n = 1'b0;
        idle(HALF);
    endtask

    task automatic cs_end();
        idle(HALF);
        cs_n = 1'b1;
        idle(2 * HALF);
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_begin(); xfer(op, 8, 0); cs_end();
    endtask

    task automatic rdsr_expect(input logic [7:0] v, input string tag);
        cs_begin(); xfer(8'h05, 8, 0);
        expect_byte(v, tag); xfer(8'h00, 8, 1);
        cs_end();
    endtask

    task automatic wr_page(input logic [9:0] a, input int n);
        cs_begin();
        xfer(8'h02, 8, 0); xfer({6'b0, a[9:8]}, 8, 0); xfer(a[7:0], 8, 0);
        for (int i = 0; i < n; i++) xfer(dbuf[i], 8, 0);
        cs_end();
    endtask

    task automatic rd_check(input logic [9:0] a, input int n, input string tag);
        cs_begin();
        xfer(8'h03, 8, 0); xfer({6'b0, a[9:8]}, 8, 0); xfer(a[7:0], 8, 0);
        for (int i = 0; i < n; i++) begin
            expect_byte(dbuf[i], tag);
            xfer(8'h00, 8, 1);
        end
        cs_end();
    endtask

    task automatic wrsr(input logic [7:0] v);
        cs_begin(); xfer(8'h01, 8, 0); xfer(v, 8, 0); cs_end();
    endtask

    task automatic wait_done();
        idle(WC + 100);
    endtask

    initial begin
        idle(10);
        checks++;
        if (so !== 1'b0) begin
            errors++;
            $display("FAIL R1: so during reset actual %b expected 0", so);
        end
        rst_n = 1'b1;
        idle(10);
        rdsr_expect(8'h00, "R1 reset status");

        // R6: no latch, nothing happens
        dbuf[0] = 8'h11;
        wr_page(10'h010, 1);
        rdsr_expect(8'h00, "R6 write without latch");
        wrsr(8'h04);
        rdsr_expect(8'h00, "R6 status write without latch");

        // R4
        cmd1(8'h06); rdsr_expect(8'h02, "R4 latch set");
        cmd1(8'h04); rdsr_expect(8'h00, "R4 latch clear");

        // R7 / R8
        cmd1(8'h06);
        dbuf[0] = 8'hA0; dbuf[1] = 8'hA1; dbuf[2] = 8'hA2; dbuf[3] = 8'hA3;
        wr_page(10'h010, 4);
        rdsr_expect(8'h01, "R7 busy and latch cleared");
        cmd1(8'h06);
        dbuf[0] = 8'h00;
        rd_check(10'h010, 1, "R8 read ignored while busy");
        rdsr_expect(8'h01, "R8 latch command ignored while busy");
        wait_done();
        rdsr_expect(8'h00, "R7 busy ends");

        // R5 / R2: mode 3 read
        mode3 = 1'b1;
        dbuf[0] = 8'hA0; dbuf[1] = 8'hA1; dbuf[2] = 8'hA2; dbuf[3] = 8'hA3;
        rd_check(10'h010, 4, "R5 R2 mode 3 stream read");
        mode3 = 1'b0;

        // R9: page wrap
        cmd1(8'h06);
        dbuf[0] = 8'hB0; dbuf[1] = 8'hB1; dbuf[2] = 8'hB2; dbuf[3] = 8'hB3; dbuf[4] = 8'hB4;
        wr_page(10'h02E, 5);
        wait_done();
        dbuf[0] = 8'hB2; dbuf[1] = 8'hB3; dbuf[2] = 8'hB4;
        rd_check(10'h020, 3, "R9 wrapped bytes at page start");
        dbuf[0] = 8'hB0; dbuf[1] = 8'hB1;
        rd_check(10'h02E, 2, "R9 bytes before wrap");

        // R5: array-end wrap
        cmd1(8'h06); dbuf[0] = 8'hC0; wr_page(10'h3FF, 1); wait_done();
        cmd1(8'h06); dbuf[0] = 8'hC1; wr_page(10'h000, 1); wait_done();
        dbuf[0] = 8'hC0; dbuf[1] = 8'hC1;
        rd_check(10'h3FF, 2, "R5 address wrap to zero");

        // R2: mode 3 write
        mode3 = 1'b1;
        cmd1(8'h06); dbuf[0] = 8'hD0; dbuf[1] = 8'hD1; wr_page(10'h050, 2); wait_done();
        mode3 = 1'b0;
        rd_check(10'h050, 2, "R2 mode 3 write, mode 0 read");

        // R10: partial byte and empty write
        cmd1(8'h06);
        cs_begin();
        xfer(8'h02, 8, 0); xfer(8'h00, 8, 0); xfer(8'h60, 8, 0);
        xfer(8'hE0, 8, 0); xfer(8'hE1, 4, 0);
        cs_end();
        rdsr_expect(8'h02, "R10 mid-byte abort");
        wr_page(10'h060, 0);
        rdsr_expect(8'h02, "R10 no data byte");

        // R11 / R3: lock field 001 first page
        wrsr(8'h04);
        rdsr_expect(8'h05, "R3 R11 status write busy");
        wait_done();
        cmd1(8'h06); dbuf[0] = 8'hF0; wr_page(10'h000, 1);
        rdsr_expect(8'h06, "R11 first page locked");
        dbuf[0] = 8'hC1;
        rd_check(10'h000, 1, "R11 locked data kept");
        dbuf[0] = 8'hF1; wr_page(10'h010, 1);
        rdsr_expect(8'h05, "R11 page 1 open");
        wait_done();
        rd_check(10'h010, 1, "R11 page 1 written");

        // 010 last page
        cmd1(8'h06); wrsr(8'h08); wait_done();
        cmd1(8'h06); dbuf[0] = 8'hF2; wr_page(10'h3FF, 1);
        rdsr_expect(8'h0A, "R11 last page locked");
        dbuf[0] = 8'hC0;
        rd_check(10'h3FF, 1, "R11 last page data kept");

        // 011 lower half
        wrsr(8'h0C); wait_done();
        cmd1(8'h06); dbuf[0] = 8'hF3; wr_page(10'h1F0, 1);
        rdsr_expect(8'h0E, "R11 lower half locked");
        wr_page(10'h200, 1);
        rdsr_expect(8'h0D, "R11 upper half open");
        wait_done();

        // 110 quarter 2
        cmd1(8'h06); wrsr(8'h18); wait_done();
        cmd1(8'h06); wr_page(10'h250, 1);
        rdsr_expect(8'h1A, "R11 quarter 2 locked");
        wr_page(10'h100, 1);
        rdsr_expect(8'h19, "R11 quarter 1 open");
        wait_done();
        cmd1(8'h06); wrsr(8'h00); wait_done();
        rdsr_expect(8'h00, "R11 lock cleared");

        // R12: write protect
        wp_n = 1'b0;
        cmd1(8'h06); dbuf[0] = 8'h77; wr_page(10'h070, 1);
        rdsr_expect(8'h02, "R12 array write blocked");
        wrsr(8'h04);
        rdsr_expect(8'h02, "R12 status write blocked");
        wp_n = 1'b1;
        wr_page(10'h070, 1);
        rdsr_expect(8'h01, "R12 released");
        wait_done();
        rd_check(10'h070, 1, "R12 data after release");

        // R3: repeated status byte
        cmd1(8'h06);
        cs_begin(); xfer(8'h05, 8, 0);
        expect_byte(8'h02, "R3 status repeat 1"); xfer(8'h00, 8, 1);
        expect_byte(8'h02, "R3 status repeat 2"); xfer(8'h00, 8, 1);
        cs_end();
        cmd1(8'h04);

        idle(20);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule